// File: doc/BRIEF.md
# Select-Decoded SPI Relay with Local Control Register

This block joins a host SPI bus to an internal SPI bus that serves two downstream devices: a converter (ADC) and a serial SRAM. The host drives two encoded target-select pins. The code on those pins picks one of three targets. For the ADC or the SRAM, the block passes the host clock and data through to the internal bus, pulls the matching internal active-low chip select, and returns the device's output to the host. For its own code, the block acts as an SPI peripheral. It holds an 8-bit control word that carries the acquisition length code and a self-clearing start bit.

During a collection burst, an on-chip acquisition sequencer raises a busy flag and takes over the whole internal bus, so that it can stream samples into the SRAM. While the flag is high, the host cannot reach either downstream device. Once collection ends, the host reads the SRAM back through the same relay path.

The routing path is combinational from the pins, so relayed transfers add no clock latency. Local register accesses are oversampled: every host pin passes through a synchronizer into the block clock domain.

Top module: `spi_route_hub`

## Requirements
- R1: The target code {tgt_sel[1], tgt_sel[0]} decodes as 2'b00 = no target, 2'b01 = local register, 2'b10 = ADC (int_cs_adc_n low), 2'b11 = SRAM (int_cs_sram_n low). At most one internal chip select is low at any time.
- R2: When seq_busy is low and the code is ADC or SRAM, int_sclk follows host_sclk, int_sdi follows host_sdi, and host_sdo follows int_sdo.
- R3: A local access is SPI mode 0, MSB first. Data is sampled on the rising host_sclk edge. When the local code is released after exactly 8 bits, the word is committed, and run_len shows word bits 2:1.
- R4: During a local access, host_sdo shifts out the stored word, MSB first, with bit 0 read as 0. Each new bit appears after a falling host_sclk edge.
- R5: A committed word with bit 0 set produces a run_pulse exactly one clock long. Bit 0 is never stored.
- R6: A local access that ends with a bit count other than 8 leaves the stored word and run_len unchanged and produces no run_pulse.
- R7: While seq_busy is high, int_sclk, int_sdi, int_cs_adc_n and int_cs_sram_n are driven from the sequencer inputs. seq_sdo always carries int_sdo.
- R8: While seq_busy is high, the ADC and SRAM codes from the host reach no internal signal, and host_sdo is held high.
- R9: A commit that happens while seq_busy is high stores the word but suppresses run_pulse.
- R10: After reset, the stored word is 0, run_len is 0, run_pulse is low, and both internal chip selects are high. With no target selected, host_sdo is high.
- R11: When the sequencer is not busy and no downstream target is selected (code 00 or 01), int_sclk and int_sdi are held low and both internal chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the host SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_sel | input | 2 | Encoded host target select |
| host_sclk | input | 1 | Host SPI clock |
| host_sdi | input | 1 | Host-to-block serial data |
| host_sdo | output | 1 | Block-to-host serial data |
| int_sclk | output | 1 | Internal bus clock |
| int_sdi | output | 1 | Internal bus data toward devices |
| int_sdo | input | 1 | Internal bus data from the selected device |
| int_cs_adc_n | output | 1 | Internal ADC chip select, active low |
| int_cs_sram_n | output | 1 | Internal SRAM chip select, active low |
| seq_busy | input | 1 | Sequencer owns the internal bus |
| seq_sclk | input | 1 | Sequencer bus clock |
| seq_sdi | input | 1 | Sequencer bus data toward devices |
| seq_cs_adc_n | input | 1 | Sequencer ADC select, active low |
| seq_cs_sram_n | input | 1 | Sequencer SRAM select, active low |
| seq_sdo | output | 1 | Internal device data returned to the sequencer |
| run_len | output | 2 | Acquisition length code from the stored word |
| run_pulse | output | 1 | One-cycle start strobe |

## Verification
Two functions can land in the same clock cycle: committing a host register write, and the sequencer taking the bus. The test provokes this by raising seq_busy at the same instant the local code is released, so the busy flag is already high in the cycle where the synchronized deselect commits the word. The outcome is judged at the ports. The length code must take the new value. No run_pulse may appear in the cycles that follow. A second bit-count test confirms that a write landing on no such collision still fires the pulse.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'b00,
    TGT_LOCAL = 2'b01,
    TGT_ADC   = 2'b10,
    TGT_SRAM  = 2'b11
  } tgt_e;

  function automatic tgt_e decode_tgt(input logic [1:0] code);
    tgt_e t;
    case (code)
      2'b01:   t = TGT_LOCAL;
      2'b10:   t = TGT_ADC;
      2'b11:   t = TGT_SRAM;
      default: t = TGT_NONE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= pin_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign pin_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_local_reg.sv
module spi_local_reg #(
  parameter int REG_W = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic             seq_busy,
  output logic             tx_bit,
  output logic [LEN_W-1:0] run_len,
  output logic             run_pulse
);

  localparam int CNT_W   = $clog2(REG_W + 2);
  localparam int LEN_LSB = 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(REG_W);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(REG_W + 1);

  logic [REG_W-1:0] word_q, word_d;
  logic [REG_W-1:0] rx_q, rx_d;
  logic [REG_W-1:0] tx_q, tx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sclk_q;
  logic             pulse_q, pulse_d;
  logic             start_xfer, end_xfer, rise, fall, commit;

  assign start_xfer = sel_s & ~sel_q;
  assign end_xfer   = ~sel_s & sel_q;
  assign rise       = sel_s & sclk_s & ~sclk_q;
  assign fall       = sel_s & ~sclk_s & sclk_q;
  assign commit     = end_xfer & (cnt_q == FULL_CNT);

  always_comb begin
    word_d  = word_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (start_xfer) begin
      tx_d  = {word_q[REG_W-1:1], 1'b0};
      rx_d  = '0;
      cnt_d = '0;
    end else begin
      if (rise) begin
        rx_d = {rx_q[REG_W-2:0], sdi_s};
        if (cnt_q != SAT_CNT) cnt_d = cnt_q + 1'b1;
      end
      if (fall) begin
        tx_d = {tx_q[REG_W-2:0], 1'b0};
      end
    end
    if (commit) begin
      word_d  = {rx_q[REG_W-1:1], 1'b0};
      pulse_d = rx_q[0] & ~seq_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      sclk_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_s;
      sclk_q  <= sclk_s;
      pulse_q <= pulse_d;
    end
  end

  assign tx_bit    = tx_q[REG_W-1];
  assign run_len   = word_q[LEN_LSB +: LEN_W];
  assign run_pulse = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |=> !run_pulse); // R5

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> $stable(run_len)); // R3

  AST_RUN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |-> !$past(seq_busy)); // R9

endmodule

// File: rtl/spi_bus_mux.sv
module spi_bus_mux
  import spi_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tgt_e tgt,
  input  logic seq_busy,
  input  logic host_sclk,
  input  logic host_sdi,
  input  logic tx_bit,
  input  logic int_sdo,
  input  logic seq_sclk,
  input  logic seq_sdi,
  input  logic seq_cs_adc_n,
  input  logic seq_cs_sram_n,
  output logic host_sdo,
  output logic int_sclk,
  output logic int_sdi,
  output logic int_cs_adc_n,
  output logic int_cs_sram_n
);

  logic host_dev;

  assign host_dev = (tgt == TGT_ADC) || (tgt == TGT_SRAM);

  always_comb begin
    if (seq_busy) begin
      int_sclk      = seq_sclk;
      int_sdi       = seq_sdi;
      int_cs_adc_n  = seq_cs_adc_n;
      int_cs_sram_n = seq_cs_sram_n;
    end else if (host_dev) begin
      int_sclk      = host_sclk;
      int_sdi       = host_sdi;
      int_cs_adc_n  = (tgt != TGT_ADC);
      int_cs_sram_n = (tgt != TGT_SRAM);
    end else begin
      int_sclk      = 1'b0;
      int_sdi       = 1'b0;
      int_cs_adc_n  = 1'b1;
      int_cs_sram_n = 1'b1;
    end
  end

  always_comb begin
    case (tgt)
      TGT_LOCAL:        host_sdo = tx_bit;
      TGT_ADC, TGT_SRAM: host_sdo = seq_busy ? 1'b1 : int_sdo;
      default:          host_sdo = 1'b1;
    endcase
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !(!int_cs_adc_n && !int_cs_sram_n)); // R1

  AST_BUSY_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && host_dev) |-> host_sdo); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !host_dev) |-> (int_cs_adc_n && int_cs_sram_n && !int_sclk)); // R11

endmodule

// File: rtl/spi_route_hub.sv
module spi_route_hub
  import spi_route_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tgt_sel,
  input  logic             host_sclk,
  input  logic             host_sdi,
  output logic             host_sdo,
  output logic             int_sclk,
  output logic             int_sdi,
  input  logic             int_sdo,
  output logic             int_cs_adc_n,
  output logic             int_cs_sram_n,
  input  logic             seq_busy,
  input  logic             seq_sclk,
  input  logic             seq_sdi,
  input  logic             seq_cs_adc_n,
  input  logic             seq_cs_sram_n,
  output logic             seq_sdo,
  output logic [LEN_W-1:0] run_len,
  output logic             run_pulse
);

  localparam int SYNC_W = 4;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [SYNC_W-1:0] pins_raw, pins_s;
  logic              sel_local_s;
  logic              tx_bit;
  tgt_e              tgt_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pins_raw = {tgt_sel, host_sclk, host_sdi};

  spi_pin_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_in  (pins_raw),
    .pin_out (pins_s)
  );

  assign sel_local_s = (decode_tgt(pins_s[3:2]) == TGT_LOCAL);
  assign tgt_now     = decode_tgt(tgt_sel);

  spi_local_reg #(.REG_W(REG_W), .LEN_W(LEN_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_s     (sel_local_s),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .seq_busy  (seq_busy),
    .tx_bit    (tx_bit),
    .run_len   (run_len),
    .run_pulse (run_pulse)
  );

  spi_bus_mux u_mux (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .tgt           (tgt_now),
    .seq_busy      (seq_busy),
    .host_sclk     (host_sclk),
    .host_sdi      (host_sdi),
    .tx_bit        (tx_bit),
    .int_sdo       (int_sdo),
    .seq_sclk      (seq_sclk),
    .seq_sdi       (seq_sdi),
    .seq_cs_adc_n  (seq_cs_adc_n),
    .seq_cs_sram_n (seq_cs_sram_n),
    .host_sdo      (host_sdo),
    .int_sclk      (int_sclk),
    .int_sdi       (int_sdi),
    .int_cs_adc_n  (int_cs_adc_n),
    .int_cs_sram_n (int_cs_sram_n)
  );

  assign seq_sdo = int_sdo;

  AST_PULSE_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(seq_busy) && seq_busy) |-> !run_pulse); // R9

endmodule

// File: tb/spi_route_hub_bench.sv
`timescale 1ns/1ps
module spi_route_hub_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] tgt_sel;
  logic       host_sclk, host_sdi, host_sdo;
  logic       int_sclk, int_sdi, int_sdo, int_cs_adc_n, int_cs_sram_n;
  logic       seq_busy, seq_sclk, seq_sdi, seq_cs_adc_n, seq_cs_sram_n, seq_sdo;
  logic [1:0] run_len;
  logic       run_pulse;

  int checks = 0;
  int fails  = 0;
  int pulse_cnt = 0;

  localparam int HALF = 8;

  always #4 clk = ~clk;

  spi_route_hub u_spi_route_hub (
    .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel),
    .host_sclk(host_sclk), .host_sdi(host_sdi), .host_sdo(host_sdo),
    .int_sclk(int_sclk), .int_sdi(int_sdi), .int_sdo(int_sdo),
    .int_cs_adc_n(int_cs_adc_n), .int_cs_sram_n(int_cs_sram_n),
    .seq_busy(seq_busy), .seq_sclk(seq_sclk), .seq_sdi(seq_sdi),
    .seq_cs_adc_n(seq_cs_adc_n), .seq_cs_sram_n(seq_cs_sram_n),
    .seq_sdo(seq_sdo), .run_len(run_len), .run_pulse(run_pulse)
  );

  always @(posedge clk) if (run_pulse) pulse_cnt <= pulse_cnt + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Local access of nbits; returns bits read on host_sdo at each rising edge.
  task automatic local_xfer(input int nbits, input logic [7:0] wdata,
                            input bit busy_at_end, output logic [7:0] rdata);
    rdata = '0;
    tgt_sel = 2'b01;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      host_sdi = wdata[7-i];
      wait_clk(HALF);
      host_sclk = 1'b1;
      rdata = {rdata[6:0], host_sdo};
      wait_clk(HALF);
      host_sclk = 1'b0;
    end
    wait_clk(HALF);
    tgt_sel = 2'b00;
    if (busy_at_end) seq_busy = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic t_reset;
    chk("R10 run_len", {6'd0, run_len}, 8'h00);
    chk("R10 run_pulse", {7'd0, run_pulse}, 8'h00);
    chk("R10 cs", {6'd0, int_cs_adc_n, int_cs_sram_n}, 8'h03);
    chk("R10 host_sdo idle", {7'd0, host_sdo}, 8'h01);
  endtask

  task automatic t_write_run;
    logic [7:0] rd;
    int p0 = pulse_cnt;
    local_xfer(8, 8'hA5, 1'b0, rd);
    chk("R3 run_len", {6'd0, run_len}, 8'h02);
    chk("R5 single pulse", 8'(pulse_cnt - p0), 8'h01);
    local_xfer(8, 8'h00, 1'b0, rd);
    chk("R4 readback bit0 clear", rd, 8'hA4);
    chk("R5 no pulse on zero", 8'(pulse_cnt - p0), 8'h01);
    chk("R11 local keeps bus quiet", {6'd0, int_cs_adc_n, int_cs_sram_n}, 8'h03);
  endtask

  task automatic t_short;
    logic [7:0] rd;
    int p0;
    local_xfer(8, 8'h5C, 1'b0, rd);
    p0 = pulse_cnt;
    local_xfer(5, 8'hFF, 1'b0, rd);
    chk("R6 short keeps len", {6'd0, run_len}, 8'h02);
    chk("R6 short no pulse", 8'(pulse_cnt - p0), 8'h00);
    local_xfer(8, 8'h00, 1'b0, rd);
    chk("R6 word kept", rd, 8'h5C);
  endtask

  task automatic t_pass(input logic [1:0] code);
    tgt_sel = code; host_sclk = 1'b0; host_sdi = 1'b0; #2;
    chk("R1 adc cs", {7'd0, int_cs_adc_n}, {7'd0, code != 2'b10});
    chk("R1 sram cs", {7'd0, int_cs_sram_n}, {7'd0, code != 2'b11});
    host_sclk = 1'b1; host_sdi = 1'b1; int_sdo = 1'b0; #2;
    chk("R2 sclk/sdi relay", {6'd0, int_sclk, int_sdi}, 8'h03);
    chk("R2 sdo return low", {7'd0, host_sdo}, 8'h00);
    int_sdo = 1'b1; #2;
    chk("R2 sdo return high", {7'd0, host_sdo}, 8'h01);
    host_sclk = 1'b0; host_sdi = 1'b0; tgt_sel = 2'b00; #2;
    chk("R11 idle quiet", {5'd0, int_sclk, int_cs_adc_n, int_cs_sram_n}, 8'h03);
    wait_clk(4);
  endtask

  task automatic t_busy;
    seq_busy = 1'b1; seq_sclk = 1'b1; seq_sdi = 1'b1;
    seq_cs_adc_n = 1'b1; seq_cs_sram_n = 1'b0;
    tgt_sel = 2'b10; host_sclk = 1'b0; host_sdi = 1'b0; int_sdo = 1'b0; #2;
    chk("R7 seq owns bus", {4'd0, int_sclk, int_sdi, int_cs_adc_n, int_cs_sram_n}, 8'h0E);
    chk("R8 host sdo high", {7'd0, host_sdo}, 8'h01);
    chk("R7 seq_sdo", {7'd0, seq_sdo}, 8'h00);
    int_sdo = 1'b1; #2;
    chk("R7 seq_sdo high", {7'd0, seq_sdo}, 8'h01);
    tgt_sel = 2'b11; #2;
    chk("R8 sram blocked", {7'd0, host_sdo}, 8'h01);
    chk("R8 cs from seq", {6'd0, int_cs_adc_n, int_cs_sram_n}, 8'h02);
    tgt_sel = 2'b00; seq_busy = 1'b0; seq_sclk = 1'b0; seq_sdi = 1'b0;
    seq_cs_sram_n = 1'b1; int_sdo = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_collide;
    logic [7:0] rd;
    int p0 = pulse_cnt;
    local_xfer(8, 8'h07, 1'b1, rd);
    wait_clk(6);
    chk("R9 len stored under busy", {6'd0, run_len}, 8'h03);
    chk("R9 pulse suppressed", 8'(pulse_cnt - p0), 8'h00);
    seq_busy = 1'b0;
    wait_clk(4);
    local_xfer(8, 8'h03, 1'b0, rd);
    chk("R9 pulse when free", 8'(pulse_cnt - p0), 8'h01);
    chk("R3 len after", {6'd0, run_len}, 8'h01);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tgt_sel = 2'b00; host_sclk = 1'b0; host_sdi = 1'b0;
    int_sdo = 1'b0; seq_busy = 1'b0; seq_sclk = 1'b0; seq_sdi = 1'b0;
    seq_cs_adc_n = 1'b1; seq_cs_sram_n = 1'b1;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset();
    t_write_run();
    t_short();
    t_pass(2'b10);
    t_pass(2'b11);
    t_busy();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule